// File: doc/BRIEF.md
# Wave-Ordered Memory Request Sequencer

This block stands between a field of dataflow processing elements and a single-ported data memory. Processing elements hand it load, store and no-op requests in whatever order their operands happen to become ready. Every request names the wave it belongs to and carries three sequence annotations: the number of the memory operation that comes before it, its own number, and the number of the one that comes after it. From these links the sequencer rebuilds the program order. It sends accesses to memory one at a time in that order and finishes each wave before it starts the next one.

Branches and joins are expressed with a wildcard link. A path that has no memory operation of its own is filled with a no-op, so that every path forms a complete chain. Requests flagged as unordered skip the chain and go out whenever no ordered request is ready. Load results come back on a response stream together with the tag the requester supplied. Up to sixteen requests can wait in the block at once.

Top module: `wo_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is high and neither `mem_en` nor `rsp_valid` is asserted.
- R2: Within the current wave, the first access sent to memory is the request whose predecessor field is the none code (all ones, 63 with 6-bit fields). After that, a request may go only if its predecessor equals the own number of the last ordered request sent. The memory sees the accesses in this order whatever order the requests arrived in.
- R3: A request whose predecessor is the wildcard code (all ones minus one, 62) may go once the last ordered request sent named this request's own number as its successor.
- R4: A request of kind no-op (kind code 2; load is 0 and store is 1) advances the chain like any other request but never asserts `mem_en`.
- R5: When an ordered request whose successor is the none code has been sent, the current wave number goes up by one. Requests tagged with any other wave wait in the buffer until their wave becomes current. The wave number only ever changes by +1.
- R6: A request with `req_unord` set ignores wave and chain. It is sent in any cycle in which no ordered request can go.
- R7: A load answers with `rsp_valid`, its tag and the memory word two cycles after its `mem_en` cycle. The word reflects every store that came earlier in program order.
- R8: The buffer holds 16 requests. `req_ready` is low while all 16 slots are occupied, and the number held grows by at most one per cycle.
- R9: At most one request leaves the buffer per cycle. `mem_we` is only asserted together with `mem_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Buffer has a free slot |
| req_wave | input | 8 | Wave number of the request |
| req_pred | input | 6 | Predecessor sequence number, or none / wildcard code |
| req_self | input | 6 | Own sequence number |
| req_succ | input | 6 | Successor sequence number, or none / wildcard code |
| req_kind | input | 2 | 0 load, 1 store, 2 no-op |
| req_unord | input | 1 | Bypass the ordering chain |
| req_addr | input | 8 | Word address |
| req_wdata | input | 16 | Store data |
| req_tag | input | 4 | Tag echoed with load data |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when set, read otherwise |
| mem_addr | output | 8 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Read data, valid one cycle after a read strobe |
| rsp_valid | output | 1 | Load response valid |
| rsp_tag | output | 4 | Tag of the answered load |
| rsp_data | output | 16 | Loaded word |

## Verification
The hardest state to reach from the ports is a buffer that is completely full of requests which cannot go yet, with the one request that unlocks them arriving last. The stimulus fills fifteen slots with a wave's tail in scrambled order, then sends the head of the chain and checks that `req_ready` drops before the whole chain drains in program order. A second hard case is a join reached through a wildcard predecessor after a no-op branch. It is driven as a three-request wave sent in reverse. Another is an unordered load that overtakes a wave whose head has not yet arrived.

// File: rtl/wo_pkg.sv
package wo_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_NOP   = 2'd2
  } op_kind_e;
endpackage

// File: rtl/wo_pick.sv
// Lowest-index first picker over a request vector.
module wo_pick #(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [N:0] below;
  assign below[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign gnt[i]     = req[i] & ~below[i];
    assign below[i+1] = below[i] | req[i];
  end
  assign any = below[N];

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/wo_link_match.sv
// Decides whether one buffered ordered request continues the chain.
module wo_link_match #(
  parameter int SEQ_W  = 6,
  parameter int WAVE_W = 8
) (
  input  logic              busy,
  input  logic              unord,
  input  logic [WAVE_W-1:0] wave,
  input  logic [WAVE_W-1:0] cur_wave,
  input  logic [SEQ_W-1:0]  pred,
  input  logic [SEQ_W-1:0]  self_no,
  input  logic              started,
  input  logic [SEQ_W-1:0]  last_self,
  input  logic [SEQ_W-1:0]  last_succ,
  output logic              hit
);
  localparam logic [SEQ_W-1:0] CODE_NONE = '1;
  localparam logic [SEQ_W-1:0] CODE_WILD = CODE_NONE - 1'b1;

  logic link_ok;
  always_comb begin
    if (!started) begin
      link_ok = (pred == CODE_NONE);
    end else begin
      link_ok = (pred == last_self) ||
                ((pred == CODE_WILD) && (last_succ == self_no));
    end
    hit = busy && !unord && (wave == cur_wave) && link_ok;
  end
endmodule

// File: rtl/wo_rsp_pipe.sv
// Carries a load's tag alongside the memory latency and captures read data.
module wo_rsp_pipe #(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_go,
  input  logic [TAG_W-1:0]  load_tag,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [DATA_W-1:0] rsp_data
);
  logic             s1_v, s2_v;
  logic [TAG_W-1:0] s1_tag, s2_tag;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v      <= 1'b0;
      s2_v      <= 1'b0;
      rsp_valid <= 1'b0;
      s1_tag    <= '0;
      s2_tag    <= '0;
      rsp_tag   <= '0;
      rsp_data  <= '0;
    end else begin
      s1_v      <= load_go;
      s1_tag    <= load_tag;
      s2_v      <= s1_v;
      s2_tag    <= s1_tag;
      rsp_valid <= s2_v;
      rsp_tag   <= s2_tag;
      if (s2_v) rsp_data <= mem_rdata;
    end
  end
endmodule

// File: rtl/wo_seq.sv
module wo_seq #(
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 6,
  parameter int WAVE_W = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WAVE_W-1:0] req_wave,
  input  logic [SEQ_W-1:0]  req_pred,
  input  logic [SEQ_W-1:0]  req_self,
  input  logic [SEQ_W-1:0]  req_succ,
  input  logic [1:0]        req_kind,
  input  logic              req_unord,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [DATA_W-1:0] rsp_data
);
  import wo_pkg::*;

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [SEQ_W-1:0] CODE_NONE = '1;

  // request buffer
  logic [DEPTH-1:0]  slot_v;
  logic [WAVE_W-1:0] e_wave  [DEPTH];
  logic [SEQ_W-1:0]  e_pred  [DEPTH];
  logic [SEQ_W-1:0]  e_self  [DEPTH];
  logic [SEQ_W-1:0]  e_succ  [DEPTH];
  op_kind_e          e_kind  [DEPTH];
  logic [DEPTH-1:0]  e_unord;
  logic [ADDR_W-1:0] e_addr  [DEPTH];
  logic [DATA_W-1:0] e_wdata [DEPTH];
  logic [TAG_W-1:0]  e_tag   [DEPTH];

  // chain state
  logic [WAVE_W-1:0] cur_wave;
  logic              started;
  logic [SEQ_W-1:0]  last_self;
  logic [SEQ_W-1:0]  last_succ;

  // slot allocation
  logic [DEPTH-1:0] free_gnt;
  logic [IDX_W-1:0] free_idx;
  logic             free_any;
  logic             accept;

  wo_pick #(.N(DEPTH)) u_free (
    .req (~slot_v),
    .gnt (free_gnt),
    .idx (free_idx),
    .any (free_any)
  );

  assign req_ready = free_any;
  assign accept    = req_valid && free_any;

  // readiness of each slot
  logic [DEPTH-1:0] ord_hit;
  logic [DEPTH-1:0] un_hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    wo_link_match #(.SEQ_W(SEQ_W), .WAVE_W(WAVE_W)) u_match (
      .busy      (slot_v[i]),
      .unord     (e_unord[i]),
      .wave      (e_wave[i]),
      .cur_wave  (cur_wave),
      .pred      (e_pred[i]),
      .self_no   (e_self[i]),
      .started   (started),
      .last_self (last_self),
      .last_succ (last_succ),
      .hit       (ord_hit[i])
    );
    assign un_hit[i] = slot_v[i] && e_unord[i];
  end

  logic [DEPTH-1:0] ord_gnt, un_gnt;
  logic [IDX_W-1:0] ord_idx, un_idx;
  logic             ord_any, un_any;

  wo_pick #(.N(DEPTH)) u_pick_ord (
    .req (ord_hit),
    .gnt (ord_gnt),
    .idx (ord_idx),
    .any (ord_any)
  );

  wo_pick #(.N(DEPTH)) u_pick_un (
    .req (un_hit),
    .gnt (un_gnt),
    .idx (un_idx),
    .any (un_any)
  );

  // ordered requests win; the bypass path fills idle cycles
  logic             issue_ord, issue_un, issue;
  logic [IDX_W-1:0] sel;
  op_kind_e         sel_kind;
  logic             load_go;

  always_comb begin
    issue_ord = ord_any;
    issue_un  = !ord_any && un_any;
    issue     = issue_ord || issue_un;
    sel       = issue_ord ? ord_idx : un_idx;
    sel_kind  = e_kind[sel];
    load_go   = issue && (sel_kind == OP_LOAD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_v    <= '0;
      cur_wave  <= '0;
      started   <= 1'b0;
      last_self <= '0;
      last_succ <= '0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      if (accept) begin
        slot_v[free_idx] <= 1'b1;
      end
      if (issue) begin
        slot_v[sel] <= 1'b0;
      end

      mem_en    <= issue && (sel_kind != OP_NOP);
      mem_we    <= issue && (sel_kind == OP_STORE);
      mem_addr  <= e_addr[sel];
      mem_wdata <= e_wdata[sel];

      if (issue_ord) begin
        if (e_succ[sel] == CODE_NONE) begin
          cur_wave <= cur_wave + 1'b1;
          started  <= 1'b0;
        end else begin
          started  <= 1'b1;
        end
        last_self <= e_self[sel];
        last_succ <= e_succ[sel];
      end
    end
  end

  // payload storage, no reset needed
  always_ff @(posedge clk) begin
    if (accept) begin
      e_wave[free_idx]  <= req_wave;
      e_pred[free_idx]  <= req_pred;
      e_self[free_idx]  <= req_self;
      e_succ[free_idx]  <= req_succ;
      e_kind[free_idx]  <= op_kind_e'(req_kind);
      e_unord[free_idx] <= req_unord;
      e_addr[free_idx]  <= req_addr;
      e_wdata[free_idx] <= req_wdata;
      e_tag[free_idx]   <= req_tag;
    end
  end

  wo_rsp_pipe #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst       (rst),
    .load_go   (load_go),
    .load_tag  (e_tag[sel]),
    .mem_rdata (mem_rdata),
    .rsp_valid (rsp_valid),
    .rsp_tag   (rsp_tag),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/wo_seq_chk.sv
module wo_seq_chk #(
  parameter int DEPTH  = 16,
  parameter int WAVE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_en,
  input logic              mem_we,
  input logic              rsp_valid,
  input logic [WAVE_W-1:0] cur_wave,
  input logic [DEPTH-1:0]  slot_v
);
  // R1
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    $fell(rst) |-> (!mem_en && !rsp_valid));

  // R5
  p_wave_step_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_wave) |-> (cur_wave == WAVE_W'($past(cur_wave) + 1'b1)));

  // R7
  p_rsp_after_read_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(mem_en && !mem_we, 2));

  // R8
  p_fill_step_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(slot_v) <= $countones($past(slot_v)) + 1);

  // R9
  p_write_needs_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en);
endmodule

bind wo_seq wo_seq_chk #(.DEPTH(DEPTH), .WAVE_W(WAVE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .rsp_valid (rsp_valid),
  .cur_wave  (cur_wave),
  .slot_v    (slot_v)
);

// File: tb/wo_seq_test.sv
module wo_seq_test;
  localparam logic [5:0] NONE = 6'd63;
  localparam logic [5:0] WILD = 6'd62;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_wave = '0;
  logic [5:0]  req_pred = '0, req_self = '0, req_succ = '0;
  logic [1:0]  req_kind = '0;
  logic        req_unord = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [3:0]  req_tag = '0;
  logic        mem_en, mem_we;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        rsp_valid;
  logic [3:0]  rsp_tag;
  logic [15:0] rsp_data;

  always #5 clk = ~clk;

  wo_seq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_wave(req_wave), .req_pred(req_pred), .req_self(req_self),
    .req_succ(req_succ), .req_kind(req_kind), .req_unord(req_unord),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_tag(req_tag),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_tag(rsp_tag), .rsp_data(rsp_data)
  );

  // memory model: one-cycle read latency
  logic [15:0] ram [256];
  logic [15:0] ref_ram [256];
  initial begin
    for (int i = 0; i < 256; i++) begin
      ram[i] = '0;
      ref_ram[i] = '0;
    end
  end
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else        mem_rdata <= ram[mem_addr];
    end
  end

  typedef struct {
    logic        we;
    logic [7:0]  addr;
    logic [15:0] data;
    string       rq;
  } op_t;
  typedef struct {
    logic [3:0]  tag;
    logic [15:0] data;
    string       rq;
  } rsp_t;

  op_t  op_q[$];
  rsp_t rsp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // scoreboard producers, called in program order
  task automatic exp_load(input logic [7:0] a, input logic [3:0] t, input string rq);
    op_q.push_back('{1'b0, a, 16'h0, rq});
    rsp_q.push_back('{t, ref_ram[a], rq});
  endtask
  task automatic exp_store(input logic [7:0] a, input logic [15:0] d, input string rq);
    op_q.push_back('{1'b1, a, d, rq});
    ref_ram[a] = d;
  endtask

  task automatic send(input logic [7:0] w, input logic [5:0] p, input logic [5:0] s,
                      input logic [5:0] n, input logic [1:0] k, input logic u,
                      input logic [7:0] a, input logic [15:0] d, input logic [3:0] t);
    @(negedge clk);
    req_wave = w; req_pred = p; req_self = s; req_succ = n; req_kind = k;
    req_unord = u; req_addr = a; req_wdata = d; req_tag = t;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  // monitors
  always @(negedge clk) begin
    if (!rst && mem_en) begin
      if (op_q.size() == 0) begin
        check(1'b0, "R4", "unexpected memory access addr", mem_addr, 0);
      end else begin
        op_t e;
        e = op_q.pop_front();
        check(mem_we == e.we, e.rq, "mem_we", mem_we, e.we);
        check(mem_addr == e.addr, e.rq, "mem_addr", mem_addr, e.addr);
        if (e.we) check(mem_wdata == e.data, e.rq, "mem_wdata", mem_wdata, e.data);
      end
    end
    if (!rst && rsp_valid) begin
      if (rsp_q.size() == 0) begin
        check(1'b0, "R7", "unexpected response tag", rsp_tag, 0);
      end else begin
        rsp_t r;
        r = rsp_q.pop_front();
        check(rsp_tag == r.tag, r.rq, "rsp_tag", rsp_tag, r.tag);
        check(rsp_data == r.data, "R7", "rsp_data", rsp_data, r.data);
      end
    end
  end

  task automatic drain(input string rq);
    repeat (12) @(negedge clk);
    check(op_q.size() == 0, rq, "pending accesses", op_q.size(), 0);
    check(rsp_q.size() == 0, rq, "pending responses", rsp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(req_ready == 1'b1, "R1", "req_ready in reset", req_ready, 1);
    check(mem_en == 1'b0, "R1", "mem_en in reset", mem_en, 0);
    check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    check(mem_en == 1'b0 && rsp_valid == 1'b0, "R1", "quiet after reset", mem_en, 0);

    // R2: wave 0, chain 1-2-3 sent in reverse
    exp_load(8'd10, 4'd1, "R2");
    exp_store(8'd10, 16'h1234, "R2");
    exp_load(8'd10, 4'd2, "R2");
    send(8'd0, 6'd2, 6'd3, NONE, 2'd0, 1'b0, 8'd10, 16'h0, 4'd2);
    send(8'd0, 6'd1, 6'd2, 6'd3, 2'd1, 1'b0, 8'd10, 16'h1234, 4'd0);
    send(8'd0, NONE, 6'd1, 6'd2, 2'd0, 1'b0, 8'd10, 16'h0, 4'd1);
    drain("R2");

    // R3 and R4: wave 1, branch through a no-op, join on a wildcard
    exp_store(8'd20, 16'hBEEF, "R3");
    exp_load(8'd20, 4'd3, "R3");
    send(8'd1, WILD, 6'd4, NONE, 2'd0, 1'b0, 8'd20, 16'h0, 4'd3);
    send(8'd1, 6'd1, 6'd2, 6'd4, 2'd2, 1'b0, 8'd99, 16'h0, 4'd0);
    send(8'd1, NONE, 6'd1, WILD, 2'd1, 1'b0, 8'd20, 16'hBEEF, 4'd0);
    drain("R4");

    // R5: wave 3 arrives before wave 2
    exp_store(8'd30, 16'h0002, "R5");
    exp_load(8'd30, 4'd4, "R5");
    exp_store(8'd30, 16'h0003, "R5");
    send(8'd3, NONE, 6'd1, NONE, 2'd1, 1'b0, 8'd30, 16'h0003, 4'd0);
    send(8'd2, 6'd5, 6'd9, NONE, 2'd0, 1'b0, 8'd30, 16'h0, 4'd4);
    send(8'd2, NONE, 6'd5, 6'd9, 2'd1, 1'b0, 8'd30, 16'h0002, 4'd0);
    drain("R5");

    // R6: unordered load overtakes wave 4 whose head is missing
    exp_load(8'd30, 4'd5, "R6");
    exp_store(8'd31, 16'h4444, "R6");
    exp_load(8'd31, 4'd6, "R6");
    send(8'd4, 6'd1, 6'd2, NONE, 2'd0, 1'b0, 8'd31, 16'h0, 4'd6);
    send(8'd77, 6'd0, 6'd0, 6'd0, 2'd0, 1'b1, 8'd30, 16'h0, 4'd5);
    repeat (6) @(negedge clk);
    check(op_q.size() == 2, "R6", "bypass issued while chain blocked", op_q.size(), 2);
    send(8'd4, NONE, 6'd1, 6'd2, 2'd1, 1'b0, 8'd31, 16'h4444, 4'd0);
    drain("R6");

    // R8: fill the buffer with a blocked wave 5, head last
    exp_store(8'd40, 16'h0100, "R8");
    for (int i = 2; i <= 16; i++) exp_store(8'(40 + i), 16'(i), "R8");
    for (int i = 16; i >= 2; i--) begin
      send(8'd5, 6'(i - 1), 6'(i), (i == 16) ? NONE : 6'(i + 1), 2'd1, 1'b0,
           8'(40 + i), 16'(i), 4'd0);
    end
    @(negedge clk);
    check(req_ready == 1'b1, "R8", "ready with 15 held", req_ready, 1);
    check(mem_en == 1'b0, "R8", "no access while head missing", mem_en, 0);
    send(8'd5, NONE, 6'd1, 6'd2, 2'd1, 1'b0, 8'd40, 16'h0100, 4'd0);
    check(req_ready == 1'b0, "R8", "ready with 16 held", req_ready, 0);
    repeat (20) @(negedge clk);
    check(req_ready == 1'b1, "R8", "ready after drain", req_ready, 1);
    drain("R9");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule